// File: doc/BRIEF.md
# Instruction-Fetch Execution Guard

This block sits beside a CPU's memory port and classifies every instruction fetch and data access against a fixed address map. It also checks them against one region that the application defines. When a fetch breaks a rule, the block tells the memory mux to return an all-zero word in place of the real instruction. That word is an illegal opcode, so the CPU takes its trap. A separate flag reports every violation, including those caused by data accesses.

The rules are as follows:
- A fetch from the firmware scratch RAM is never allowed.
- No access may reach beyond the physically populated part of the main RAM window.
- ROM may be executed only while ROM is executable. Without that permission, only the two call-gate entry addresses may be fetched.
- Fetches inside the application region are refused once the region is armed.

The application programs the region bounds and then arms the region. Arming locks the region until reset. The trap indication coming back from the CPU is latched and drives a red LED that blinks for as long as power stays on.

Top module: `exec_guard`

## Requirements
- R1: A valid fetch whose address lies in the firmware RAM window (base 0xD000_0000, 0x800 bytes by default) is a violation in both firmware and application mode.
- R2: A fetch or data access inside the RAM window (base 0x4000_0000, 0x4000_0000 bytes) at an offset of at least the physical size (0x2_0000 by default) is a violation. The last physical word is not a violation.
- R3: ROM (base 0, 0x2000 bytes) is executable when `app_mode` is 0 or `rom_exec_grant` is 1. A ROM fetch at any other time is a violation.
- R4: When ROM is not executable, a fetch exactly at `gate_a_addr` or exactly at `gate_b_addr` is still allowed. The word that follows either address is not allowed.
- R5: Once armed, a fetch at an address A with lo ≤ A ≤ hi is a violation. The check includes both bounds. Data accesses inside the region are not affected. Before arming, the region has no effect.
- R6: Register writes use `reg_sel` 0 for the lower bound, 1 for the upper bound, and 2 for arm (`reg_wdata[0]`=1). After arming, all three writes are ignored, and the region stays armed.
- R7: `fetch_zero` is high in the same cycle as a violating fetch with `fetch_valid`=1. It stays low for invalid fetches and for data-only violations.
- R8: `violation` is high in the same cycle as any violating fetch or data access.
- R9: A cycle with `cpu_trap`=1 sets a trap-seen state that only reset clears.
- R10: Starting with the clock edge that samples the trap, `led_red` is high for BLINK_HALF cycles and then low for BLINK_HALF cycles, repeating. It is low while no trap has been seen.
- R11: After reset the bounds are zero, the region is disarmed and `led_red` is low. Arming with no bound writes therefore protects address 0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 32 | Instruction fetch byte address |
| mem_valid | input | 1 | Data access strobe |
| mem_addr | input | 32 | Data access byte address |
| app_mode | input | 1 | 1 while executing in application mode |
| rom_exec_grant | input | 1 | Extra ROM execute permission during a gated call |
| gate_a_addr | input | 32 | First call-gate entry address |
| gate_b_addr | input | 32 | Second call-gate entry address |
| reg_we | input | 1 | Region register write strobe |
| reg_sel | input | 2 | Region register select |
| reg_wdata | input | 32 | Region register write data |
| cpu_trap | input | 1 | CPU reports it has trapped |
| fetch_zero | output | 1 | Replace the fetched word with zero |
| violation | output | 1 | Any access violated a rule this cycle |
| led_red | output | 1 | Blinking red alarm drive |

## Verification
The hardest state to reach is the locked region, because the only way into it is a single arm write and only reset leads out of it. The bench arms the region and then writes new bounds together with a disarm value. It probes both the old bounds and the new ones with fetches to show that nothing moved. It then resets and arms without any bound writes, which exposes the reset values of the bounds through a fetch at address 0. The blink phase is followed cycle by cycle, using a small half-period that the bench supplies.

// File: rtl/exec_guard_pkg.sv
package exec_guard_pkg;
   localparam int ADDR_W = 32;

   typedef enum logic [1:0] {
      SEL_LO   = 2'd0,
      SEL_HI   = 2'd1,
      SEL_ARM  = 2'd2,
      SEL_NONE = 2'd3
   } guard_sel_e;

   function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base,
                                      input logic [ADDR_W-1:0] size);
      return (addr >= base) && ((addr - base) < size);
   endfunction
endpackage

// File: rtl/guard_region.sv
module guard_region
   import exec_guard_pkg::*;
#(
   parameter int AW = ADDR_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    sel,
   input  logic [AW-1:0] wdata,
   output logic [AW-1:0] lo_q,
   output logic [AW-1:0] hi_q,
   output logic          armed_q
);
   guard_sel_e sel_e;
   logic       open_wr;

   assign sel_e   = guard_sel_e'(sel);
   assign open_wr = we && !armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         armed_q <= 1'b0;
      end else if (open_wr) begin
         unique case (sel_e)
            SEL_LO:   lo_q    <= wdata;
            SEL_HI:   hi_q    <= wdata;
            SEL_ARM:  armed_q <= wdata[0];
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/guard_classify.sv
module guard_classify
   import exec_guard_pkg::*;
#(
   parameter int            AW         = ADDR_W,
   parameter logic [AW-1:0] ROM_BASE   = 32'h0000_0000,
   parameter logic [AW-1:0] ROM_SIZE   = 32'h0000_2000,
   parameter logic [AW-1:0] FWRAM_BASE = 32'hD000_0000,
   parameter logic [AW-1:0] FWRAM_SIZE = 32'h0000_0800,
   parameter logic [AW-1:0] RAM_BASE   = 32'h4000_0000,
   parameter logic [AW-1:0] RAM_WINDOW = 32'h4000_0000,
   parameter logic [AW-1:0] RAM_PHYS   = 32'h0002_0000
) (
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_addr,
   input  logic          mem_valid,
   input  logic [AW-1:0] mem_addr,
   input  logic          rom_exec,
   input  logic [AW-1:0] gate_a,
   input  logic [AW-1:0] gate_b,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   input  logic          armed,
   output logic          fetch_bad,
   output logic          data_bad
);
   logic f_fwram, f_rom, f_gate, f_region, f_beyond, d_beyond;

   assign f_fwram  = in_window(fetch_addr, FWRAM_BASE, FWRAM_SIZE);
   assign f_rom    = in_window(fetch_addr, ROM_BASE, ROM_SIZE);
   assign f_gate   = (fetch_addr == gate_a) || (fetch_addr == gate_b);
   assign f_region = armed && (fetch_addr >= lo) && (fetch_addr <= hi);

   generate
      if (RAM_PHYS >= RAM_WINDOW) begin : g_full_ram
         assign f_beyond = 1'b0;
         assign d_beyond = 1'b0;
      end else begin : g_partial_ram
         assign f_beyond = in_window(fetch_addr, RAM_BASE, RAM_WINDOW) &&
                           !in_window(fetch_addr, RAM_BASE, RAM_PHYS);
         assign d_beyond = in_window(mem_addr, RAM_BASE, RAM_WINDOW) &&
                           !in_window(mem_addr, RAM_BASE, RAM_PHYS);
      end
   endgenerate

   assign fetch_bad = fetch_valid &&
                      (f_fwram || f_beyond || f_region ||
                       (f_rom && !rom_exec && !f_gate));
   assign data_bad  = mem_valid && d_beyond;
endmodule

// File: rtl/guard_alarm.sv
module guard_alarm #(
   parameter int BLINK_HALF = 12_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_trap,
   output logic trap_seen,
   output logic led
);
   localparam int CW = (BLINK_HALF > 2) ? $clog2(BLINK_HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

   logic [CW-1:0] cnt;
   logic          phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_seen <= 1'b0;
         phase     <= 1'b0;
         cnt       <= '0;
      end else if (!trap_seen) begin
         if (cpu_trap) begin
            trap_seen <= 1'b1;
            phase     <= 1'b1;
            cnt       <= '0;
         end
      end else if (cnt == LAST) begin
         cnt   <= '0;
         phase <= !phase;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign led = trap_seen && phase;
endmodule

// File: rtl/exec_guard.sv
module exec_guard
   import exec_guard_pkg::*;
#(
   parameter logic [31:0] ROM_BASE   = 32'h0000_0000,
   parameter logic [31:0] ROM_SIZE   = 32'h0000_2000,
   parameter logic [31:0] FWRAM_BASE = 32'hD000_0000,
   parameter logic [31:0] FWRAM_SIZE = 32'h0000_0800,
   parameter logic [31:0] RAM_BASE   = 32'h4000_0000,
   parameter logic [31:0] RAM_WINDOW = 32'h4000_0000,
   parameter logic [31:0] RAM_PHYS   = 32'h0002_0000,
   parameter int          CLK_HZ     = 24_000_000,
   parameter int          BLINK_HALF = CLK_HZ / 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fetch_valid,
   input  logic [31:0] fetch_addr,
   input  logic        mem_valid,
   input  logic [31:0] mem_addr,
   input  logic        app_mode,
   input  logic        rom_exec_grant,
   input  logic [31:0] gate_a_addr,
   input  logic [31:0] gate_b_addr,
   input  logic        reg_we,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   input  logic        cpu_trap,
   output logic        fetch_zero,
   output logic        violation
   ,output logic       led_red
);
   generate
      if (BLINK_HALF < 2) begin : g_bad_blink
         $error("BLINK_HALF must be at least 2");
      end
      if (ROM_SIZE == 0 || FWRAM_SIZE == 0 || RAM_PHYS == 0) begin : g_bad_map
         $error("address windows must be non-empty");
      end
   endgenerate

   logic [31:0] lo_q, hi_q;
   logic        armed_q;
   logic        rom_exec;
   logic        fetch_bad, data_bad;
   logic        trap_seen;

   assign rom_exec = !app_mode || rom_exec_grant;

   guard_region #(.AW(ADDR_W)) u_region (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .sel     (reg_sel),
      .wdata   (reg_wdata),
      .lo_q    (lo_q),
      .hi_q    (hi_q),
      .armed_q (armed_q)
   );

   guard_classify #(
      .AW(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
      .FWRAM_BASE(FWRAM_BASE), .FWRAM_SIZE(FWRAM_SIZE),
      .RAM_BASE(RAM_BASE), .RAM_WINDOW(RAM_WINDOW), .RAM_PHYS(RAM_PHYS)
   ) u_classify (
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .mem_valid   (mem_valid),
      .mem_addr    (mem_addr),
      .rom_exec    (rom_exec),
      .gate_a      (gate_a_addr),
      .gate_b      (gate_b_addr),
      .lo          (lo_q),
      .hi          (hi_q),
      .armed       (armed_q),
      .fetch_bad   (fetch_bad),
      .data_bad    (data_bad)
   );

   guard_alarm #(.BLINK_HALF(BLINK_HALF)) u_alarm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_trap  (cpu_trap),
      .trap_seen (trap_seen),
      .led       (led_red)
   );

   assign fetch_zero = fetch_bad;
   assign violation  = fetch_bad || data_bad;
endmodule

// File: rtl/exec_guard_chk.sv
module exec_guard_chk #(
   parameter logic [31:0] FWRAM_BASE = 32'hD000_0000,
   parameter logic [31:0] FWRAM_SIZE = 32'h0000_0800
) (
   input logic        clk,
   input logic        rst_n,
   input logic        fetch_valid,
   input logic [31:0] fetch_addr,
   input logic        fetch_zero,
   input logic        violation,
   input logic        led_red,
   input logic        trap_seen,
   input logic        armed_q,
   input logic [31:0] lo_q,
   input logic [31:0] hi_q
);
   AST_FWRAM_FETCH_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_addr >= FWRAM_BASE && (fetch_addr - FWRAM_BASE) < FWRAM_SIZE)
      |-> fetch_zero); // R1
   AST_ZERO_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_zero |-> fetch_valid); // R7
   AST_ZERO_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_zero |-> violation); // R8
   AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      trap_seen |=> trap_seen); // R9
   AST_LED_NEEDS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      led_red |-> trap_seen); // R10
   AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> armed_q); // R6
   AST_BOUNDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> ($stable(lo_q) && $stable(hi_q))); // R6
endmodule

bind exec_guard exec_guard_chk #(
   .FWRAM_BASE(FWRAM_BASE), .FWRAM_SIZE(FWRAM_SIZE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
   .fetch_zero(fetch_zero), .violation(violation), .led_red(led_red),
   .trap_seen(trap_seen), .armed_q(armed_q), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/exec_guard_bench.sv
module exec_guard_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_addr = '0;
   logic        app_mode = 1'b0;
   logic        rom_exec_grant = 1'b0;
   logic [31:0] gate_a_addr = 32'h0000_0200;
   logic [31:0] gate_b_addr = 32'h0000_0400;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_wdata = '0;
   logic        cpu_trap = 1'b0;
   logic        fetch_zero, violation, led_red;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exec_guard #(.BLINK_HALF(HALF)) u_exec_guard (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .app_mode(app_mode),
      .rom_exec_grant(rom_exec_grant), .gate_a_addr(gate_a_addr),
      .gate_b_addr(gate_b_addr), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .cpu_trap(cpu_trap), .fetch_zero(fetch_zero),
      .violation(violation), .led_red(led_red)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // fetch probe: drive at negedge, check combinational outputs 1 time unit later
   task automatic probe_fetch(input string req, input logic [31:0] a,
                              input logic exp_bad);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a; mem_valid = 1'b0;
      #1;
      check(req, fetch_zero, exp_bad);
      check(req, violation, exp_bad);
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic probe_data(input string req, input logic [31:0] a,
                             input logic exp_bad);
      @(negedge clk);
      mem_valid = 1'b1; mem_addr = a; fetch_valid = 1'b0;
      #1;
      check(req, violation, exp_bad);
      check(req, fetch_zero, 1'b0);
      @(negedge clk);
      mem_valid = 1'b0;
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic t_reset_state();
      #1;
      check("R11 led after reset", led_red, 1'b0);
      check("R11 idle violation", violation, 1'b0);
      probe_fetch("R11 ROM fetch in fw mode unarmed", 32'h0000_0000, 1'b0);
   endtask

   task automatic t_fwram();
      app_mode = 1'b0;
      probe_fetch("R1 fwram base fw mode", 32'hD000_0000, 1'b1);
      app_mode = 1'b1;
      probe_fetch("R1 fwram top app mode", 32'hD000_07FC, 1'b1);
      probe_fetch("R1 past fwram", 32'hD000_0800, 1'b0);
      app_mode = 1'b0;
   endtask

   task automatic t_ram_bound();
      probe_data("R2 last physical word", 32'h4001_FFFC, 1'b0);
      probe_data("R2 first beyond physical", 32'h4002_0000, 1'b1);
      probe_fetch("R2 fetch beyond physical", 32'h4002_0000, 1'b1);
      probe_fetch("R2 fetch in physical", 32'h4000_0100, 1'b0);
   endtask

   task automatic t_rom_exec();
      app_mode = 1'b1; rom_exec_grant = 1'b0;
      probe_fetch("R3 ROM app mode no grant", 32'h0000_0100, 1'b1);
      rom_exec_grant = 1'b1;
      probe_fetch("R3 ROM app mode with grant", 32'h0000_0100, 1'b0);
      rom_exec_grant = 1'b0; app_mode = 1'b0;
      probe_fetch("R3 ROM fw mode", 32'h0000_0100, 1'b0);
   endtask

   task automatic t_gates();
      app_mode = 1'b1; rom_exec_grant = 1'b0;
      probe_fetch("R4 gate A entry", 32'h0000_0200, 1'b0);
      probe_fetch("R4 gate B entry", 32'h0000_0400, 1'b0);
      probe_fetch("R4 after gate A", 32'h0000_0204, 1'b1);
      probe_fetch("R4 after gate B", 32'h0000_0404, 1'b1);
      app_mode = 1'b0;
   endtask

   task automatic t_invalid_fetch();
      @(negedge clk);
      fetch_valid = 1'b0; fetch_addr = 32'hD000_0000;
      #1;
      check("R7 no zero without fetch_valid", fetch_zero, 1'b0);
      check("R8 no violation without strobes", violation, 1'b0);
   endtask

   task automatic t_region();
      reg_write(2'd0, 32'h4000_1000);
      reg_write(2'd1, 32'h4000_1FFC);
      probe_fetch("R5 region before arm", 32'h4000_1000, 1'b0);
      reg_write(2'd2, 32'h0000_0001);
      probe_fetch("R5 region lower bound", 32'h4000_1000, 1'b1);
      probe_fetch("R5 region upper bound", 32'h4000_1FFC, 1'b1);
      probe_fetch("R5 above region", 32'h4000_2000, 1'b0);
      probe_fetch("R5 below region", 32'h4000_0FFC, 1'b0);
      probe_data("R5 data inside region", 32'h4000_1800, 1'b0);
   endtask

   task automatic t_lock();
      reg_write(2'd0, 32'h4000_8000);
      reg_write(2'd1, 32'h4000_9000);
      reg_write(2'd2, 32'h0000_0000);
      probe_fetch("R6 new bounds ignored", 32'h4000_8000, 1'b0);
      probe_fetch("R6 old bounds kept", 32'h4000_1000, 1'b1);
   endtask

   task automatic t_blink();
      @(negedge clk);
      #1;
      check("R10 led dark before trap", led_red, 1'b0);
      @(negedge clk);
      cpu_trap = 1'b1;
      @(negedge clk);
      cpu_trap = 1'b0;
      for (int n = 0; n < 4*HALF + 3; n++) begin
         #1;
         check($sformatf("R10 blink cycle %0d", n), led_red, ((n / HALF) % 2) == 0);
         @(negedge clk);
      end
      repeat (3*HALF) @(negedge clk);
      #1;
      // 7*HALF+3 cycles after the trap edge: phase index 7 -> dark, so step in
      repeat (HALF) @(negedge clk);
      #1;
      check("R9 trap still latched", led_red, 1'b1);
   endtask

   task automatic t_reset_values();
      do_reset();
      #1;
      check("R9 reset clears alarm", led_red, 1'b0);
      reg_write(2'd2, 32'h0000_0001);
      probe_fetch("R11 bounds reset to zero", 32'h0000_0000, 1'b1);
      probe_fetch("R11 just past zero bound", 32'h0000_0004, 1'b0);
   endtask

   initial begin
      do_reset();
      t_reset_state();
      t_fwram();
      t_ram_bound();
      t_rom_exec();
      t_gates();
      t_invalid_fetch();
      t_region();
      t_lock();
      t_blink();
      t_reset_values();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule